// File: doc/BRIEF.md
# Tiered Bank Address Mapper

This block sits between the requesters of one processing element's scratch memory and the sixteen SRAM banks behind them. The banks form four tiers of four banks each. Every tier is larger than the one below it: 32, 128, 256 and 1024 words per bank. A flat word address is split into a tier, a bank inside that tier and an offset inside that bank. The block then strobes exactly one bank enable. Each tier has its own address register, and an access to one tier leaves the address lines of the other tiers untouched. This keeps the small, frequently used tiers cheap to switch.

Two kinds of requester share the memory. The first is the owning element, which always wins. The second is a set of remote elements, served lowest index first. A requester that loses is held off through its grant signal and keeps its request until it is served. A schedule register marks each bank as active or drowsy. It produces per-bank power-gate and clamp control bits. Any access that lands on a drowsy bank, or on a bank still waking, is refused with an error. A sequential mode lets a requester stepping through consecutive addresses reuse the previous decode until it crosses a bank boundary.

Top module: `tier_bank_mapper`

## Requirements
- R1: Addresses 0 to 127 map to tier 0 (32-word banks). The bank is address/32 and the offset is address mod 32. `bank_en` bit 4*tier+bank is the strobe, and the offset appears in `lvl_addr[10*tier +: 10]`.
- R2: Tiers 1, 2 and 3 start at addresses 128, 640 and 1664, with banks of 128, 256 and 1024 words, and use the same bank and field encoding as R1. Address 5759 is the last valid word.
- R3: An address of 5760 or above sets `err` for one cycle, strobes no bank and changes no tier address.
- R4: `bank_en`, `lvl_addr`, `err`, `seq_hit`, `rd_valid`, `rd_data` and `rd_src` reflect an access one cycle after it is granted. A read returns the data last written to that word.
- R5: A tier whose banks are not strobed in a cycle keeps its `lvl_addr` field unchanged.
- R6: A local request is granted in the same cycle, whatever remote requests are present. At most one grant is high at a time.
- R7: Without a local request, the lowest-numbered requesting remote is granted. The others see their grant low and are served in later cycles. `rd_src` is 0 for the local requester and i+1 for remote i.
- R8: Writing the schedule sets per-bank drowsy bits (1 = drowsy) from the next cycle on. `periph_on` is the inverse of the drowsy bit and `clamp_on` equals it. Reset leaves all banks active.
- R9: An access to a drowsy bank raises `err`, strobes no bank and does not write the array.
- R10: A bank switched from drowsy to active refuses accesses with `err` for the one cycle after the schedule write, and accepts them from the cycle after that.
- R11: With `seq_mode` high, an access from the same requester at the previous granted address plus one is served from the previous decode and flagged by `seq_hit`. If the previous offset was the last word of its bank, a full decode is used instead and `seq_hit` stays low.
- R12: After reset, all strobes, tier addresses, `err`, `seq_hit` and `rd_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_req | input | 1 | Local access request |
| loc_we | input | 1 | Local write (1) or read (0) |
| loc_addr | input | AW (13) | Local flat word address |
| loc_wdata | input | DATA_W | Local write data |
| rem_req | input | NREM | Remote requests |
| rem_we | input | NREM | Remote write flags |
| rem_addr | input | NREM*AW | Remote addresses, remote i at bits i*AW |
| rem_wdata | input | NREM*DATA_W | Remote write data |
| loc_gnt | output | 1 | Local request granted this cycle |
| rem_gnt | output | NREM | Remote grants |
| seq_mode | input | 1 | Enable sequential reuse of the previous decode |
| sched_we | input | 1 | Load the drowsy schedule |
| sched_drowsy | input | 16 | New drowsy bits, one per bank |
| periph_on | output | 16 | Peripheral power gate enable per bank |
| clamp_on | output | 16 | Array clamp enable per bank |
| bank_en | output | 16 | One-hot bank strobe |
| lvl_addr | output | 4*OW (40) | In-bank offset held per tier |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| rd_src | output | SW (2) | Requester that owns the read data |
| err | output | 1 | Access refused |
| seq_hit | output | 1 | Access served by sequential reuse |

## Verification
Grants are combinational, so the bench samples them a moment after driving the request, inside the same cycle. Every other result is registered once and is due at the first rising edge after the grant. The bench drives on a falling edge and samples on the next falling edge, before it changes any input. Schedule effects follow the same pattern: drowsy bits show at the edge after the write, and the wake window is exactly the following cycle. The wake check therefore issues its access in the very cycle after the schedule write and holds it for one more cycle.

// File: rtl/tier_bank_mapper.sv
module tier_bank_mapper #(
  parameter int DATA_W = 32,
  parameter int NREM   = 2,
  parameter int LG1    = 5,
  parameter int LG2    = 7,
  parameter int LG3    = 8,
  parameter int LG4    = 10,
  localparam int TOTAL = 4 * ((1 << LG1) + (1 << LG2) + (1 << LG3) + (1 << LG4)),
  localparam int AW    = $clog2(TOTAL),
  localparam int OW    = LG4,
  localparam int SW    = $clog2(NREM + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   loc_req,
  input  logic                   loc_we,
  input  logic [AW-1:0]          loc_addr,
  input  logic [DATA_W-1:0]      loc_wdata,
  input  logic [NREM-1:0]        rem_req,
  input  logic [NREM-1:0]        rem_we,
  input  logic [NREM*AW-1:0]     rem_addr,
  input  logic [NREM*DATA_W-1:0] rem_wdata,
  output logic                   loc_gnt,
  output logic [NREM-1:0]        rem_gnt,
  input  logic                   seq_mode,
  input  logic                   sched_we,
  input  logic [15:0]            sched_drowsy,
  output logic [15:0]            periph_on,
  output logic [15:0]            clamp_on,
  output logic [15:0]            bank_en,
  output logic [4*OW-1:0]        lvl_addr,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  output logic [SW-1:0]          rd_src,
  output logic                   err,
  output logic                   seq_hit
);

  localparam int BASE1 = 4 << LG1;
  localparam int BASE2 = BASE1 + (4 << LG2);
  localparam int BASE3 = BASE2 + (4 << LG3);

  function automatic int lg_of(input int t);
    case (t)
      0:       return LG1;
      1:       return LG2;
      2:       return LG3;
      default: return LG4;
    endcase
  endfunction

  // arbitration: local first, then lowest remote index
  logic              any;
  logic              sel_we;
  logic [AW-1:0]     sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic [SW-1:0]     sel_src;

  always_comb begin
    loc_gnt   = loc_req;
    rem_gnt   = '0;
    any       = loc_req;
    sel_we    = loc_we;
    sel_addr  = loc_addr;
    sel_wdata = loc_wdata;
    sel_src   = '0;
    if (!loc_req) begin
      for (int i = 0; i < NREM; i++) begin
        if (rem_req[i] && !any) begin
          any        = 1'b1;
          rem_gnt[i] = 1'b1;
          sel_we     = rem_we[i];
          sel_addr   = rem_addr[i*AW +: AW];
          sel_wdata  = rem_wdata[i*DATA_W +: DATA_W];
          sel_src    = SW'(i + 1);
        end
      end
    end
  end

  // full decode
  logic [AW-1:0] rel;
  logic [1:0]    dec_lvl, dec_bnk;
  logic [OW-1:0] dec_off;
  logic          in_range;

  always_comb begin
    in_range = 1'b1;
    if (sel_addr < AW'(BASE1)) begin
      dec_lvl = 2'd0; rel = sel_addr;
    end else if (sel_addr < AW'(BASE2)) begin
      dec_lvl = 2'd1; rel = sel_addr - AW'(BASE1);
    end else if (sel_addr < AW'(BASE3)) begin
      dec_lvl = 2'd2; rel = sel_addr - AW'(BASE2);
    end else begin
      dec_lvl = 2'd3; rel = sel_addr - AW'(BASE3);
      in_range = (int'(sel_addr) < TOTAL);
    end
    dec_bnk = 2'(rel >> lg_of(int'(dec_lvl)));
    dec_off = OW'(rel & ((AW'(1) << lg_of(int'(dec_lvl))) - AW'(1)));
  end

  // sequential reuse
  logic          seq_ok_q;
  logic [AW-1:0] last_addr_q;
  logic [SW-1:0] last_src_q;
  logic [1:0]    last_lvl_q, last_bnk_q;
  logic [OW-1:0] last_off_q;
  logic          at_edge, use_seq;

  assign at_edge = (last_off_q == OW'((1 << lg_of(int'(last_lvl_q))) - 1));
  assign use_seq = seq_mode && seq_ok_q && any && !at_edge &&
                   (sel_src == last_src_q) && (sel_addr == AW'(last_addr_q + 1'b1));

  logic [1:0]    lvl, bnk;
  logic [OW-1:0] off;
  logic [3:0]    gb;
  assign lvl = use_seq ? last_lvl_q : dec_lvl;
  assign bnk = use_seq ? last_bnk_q : dec_bnk;
  assign off = use_seq ? OW'(last_off_q + 1'b1) : dec_off;
  assign gb  = {lvl, bnk};

  // drowsy schedule
  logic [15:0] drowsy_q, wake_q;
  logic        go;
  assign go        = any && (use_seq || in_range) && !drowsy_q[gb] && !wake_q[gb];
  assign periph_on = ~drowsy_q;
  assign clamp_on  = drowsy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drowsy_q <= '0;
      wake_q   <= '0;
    end else if (sched_we) begin
      drowsy_q <= sched_drowsy;
      wake_q   <= drowsy_q & ~sched_drowsy;
    end else begin
      wake_q   <= '0;
    end
  end

  // registered results
  logic [3:0] gb_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_en     <= '0;
      lvl_addr    <= '0;
      err         <= 1'b0;
      seq_hit     <= 1'b0;
      rd_valid    <= 1'b0;
      rd_src      <= '0;
      gb_q        <= '0;
      seq_ok_q    <= 1'b0;
      last_addr_q <= '0;
      last_src_q  <= '0;
      last_lvl_q  <= '0;
      last_bnk_q  <= '0;
      last_off_q  <= '0;
    end else begin
      bank_en  <= go ? (16'd1 << gb) : 16'd0;
      err      <= any && !go;
      seq_hit  <= go && use_seq;
      rd_valid <= go && !sel_we;
      if (any) begin
        rd_src   <= sel_src;
        gb_q     <= gb;
        seq_ok_q <= go;
      end
      if (go) begin
        for (int k = 0; k < 4; k++)
          if (lvl == 2'(k)) lvl_addr[k*OW +: OW] <= off;
        last_addr_q <= sel_addr;
        last_src_q  <= sel_src;
        last_lvl_q  <= lvl;
        last_bnk_q  <= bnk;
        last_off_q  <= off;
      end
    end
  end

  // bank arrays
  logic [DATA_W-1:0] bank_q [16];
  for (genvar g = 0; g < 16; g++) begin : g_bank
    localparam int LG = lg_of(g / 4);
    logic [DATA_W-1:0] mem [1 << LG];
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (go && gb == 4'(g)) begin
        if (sel_we) mem[off[LG-1:0]] <= sel_wdata;
        else        q <= mem[off[LG-1:0]];
      end
    end
    assign bank_q[g] = q;
  end

  assign rd_data = rd_valid ? bank_q[gb_q] : '0;

  // assertions
  a_r1_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en));
  a_r6_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loc_gnt, rem_gnt}));
  a_r6_local_wins: assert property (@(posedge clk) disable iff (!rst_n)
    loc_req |-> (rem_gnt == '0));
  a_r7_remote_served: assert property (@(posedge clk) disable iff (!rst_n)
    (!loc_req && |rem_req) |-> |rem_gnt);
  a_r9_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (bank_en == '0 && !rd_valid && !seq_hit));
  a_r8_gate_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_on ^ clamp_on) == 16'hFFFF);
  for (genvar t = 0; t < 4; t++) begin : g_quiet
    a_r5_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_en[4*t +: 4] == 4'd0) |-> $stable(lvl_addr[t*OW +: OW]));
  end

endmodule

// File: tb/tier_bank_mapper_bench.sv
`timescale 1ns/1ps
module tier_bank_mapper_bench;
  localparam int AW = 13;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic loc_req = 0, loc_we = 0;
  logic [AW-1:0] loc_addr = '0;
  logic [DW-1:0] loc_wdata = '0;
  logic [1:0] rem_req = '0, rem_we = '0;
  logic [2*AW-1:0] rem_addr = '0;
  logic [2*DW-1:0] rem_wdata = '0;
  logic loc_gnt;
  logic [1:0] rem_gnt;
  logic seq_mode = 0, sched_we = 0;
  logic [15:0] sched_drowsy = '0;
  logic [15:0] periph_on, clamp_on, bank_en;
  logic [39:0] lvl_addr;
  logic rd_valid, err, seq_hit;
  logic [DW-1:0] rd_data;
  logic [1:0] rd_src;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  tier_bank_mapper u_tier_bank_mapper (
    .clk, .rst_n, .loc_req, .loc_we, .loc_addr, .loc_wdata,
    .rem_req, .rem_we, .rem_addr, .rem_wdata, .loc_gnt, .rem_gnt,
    .seq_mode, .sched_we, .sched_drowsy, .periph_on, .clamp_on,
    .bank_en, .lvl_addr, .rd_valid, .rd_data, .rd_src, .err, .seq_hit);

  // address, global bank (4*tier+bank), in-bank offset
  localparam int NV = 12;
  localparam int VA [NV] = '{0, 31, 32, 127, 128, 639, 640, 900, 1663, 1664, 3000, 5759};
  localparam int VB [NV] = '{0, 0, 1, 3, 4, 7, 8, 9, 11, 12, 13, 15};
  localparam int VO [NV] = '{0, 31, 0, 31, 0, 127, 0, 4, 255, 0, 312, 1023};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit we, input int addr, input logic [DW-1:0] d);
    @(negedge clk);
    loc_req = 1; loc_we = we; loc_addr = AW'(addr); loc_wdata = d;
    @(negedge clk);
    loc_req = 0; loc_we = 0;
  endtask

  function automatic int field(input int t);
    return int'(lvl_addr[t*10 +: 10]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int saved [4];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bank_en == 0 && err == 0 && rd_valid == 0 && seq_hit == 0, "R12 outputs", bank_en, 0);
    chk(lvl_addr == 0, "R12 lvl_addr", lvl_addr, 0);
    chk(periph_on == 16'hFFFF && clamp_on == 0, "R12/R8 active", periph_on, 16'hFFFF);

    for (int i = 0; i < NV; i++) begin
      access(1, VA[i], 32'hA000 + DW'(i));
      chk(bank_en == (16'd1 << VB[i]), (i < 4) ? "R1 strobe" : "R2 strobe", bank_en, 16'd1 << VB[i]);
      chk(field(VB[i] / 4) == VO[i], (i < 4) ? "R1 offset" : "R2 offset", field(VB[i] / 4), VO[i]);
      chk(err == 0 && rd_valid == 0, "R4 write flags", err, 0);
    end
    for (int i = 0; i < NV; i++) begin
      access(0, VA[i], '0);
      chk(rd_valid && rd_data == 32'hA000 + DW'(i), "R4 readback", rd_data, 32'hA000 + i);
      chk(rd_src == 0, "R7 local src", rd_src, 0);
    end

    for (int t = 0; t < 4; t++) saved[t] = field(t);
    access(0, 5, '0);
    chk(field(0) == 5, "R1 tier0 moved", field(0), 5);
    chk(field(1) == saved[1] && field(2) == saved[2] && field(3) == saved[3],
        "R5 upper tiers held", field(3), saved[3]);

    for (int t = 0; t < 4; t++) saved[t] = field(t);
    access(1, 5760, 32'hDEAD);
    chk(err == 1 && bank_en == 0, "R3 first out of range", bank_en, 0);
    chk(lvl_addr[39:30] == 10'(saved[3]) && field(0) == saved[0], "R3 tiers held", field(3), saved[3]);
    access(0, 8191, '0);
    chk(err == 1 && rd_valid == 0, "R3 top address", err, 1);

    // arbitration
    @(negedge clk);
    loc_req = 1; loc_addr = 13'd0;
    rem_req = 2'b11; rem_addr = {13'd128, 13'd32};
    #1 chk(loc_gnt == 1 && rem_gnt == 0, "R6 local first", rem_gnt, 0);
    @(negedge clk);
    chk(rd_src == 0 && rd_data == 32'hA000, "R6 local data", rd_data, 32'hA000);
    loc_req = 0;
    #1 chk(rem_gnt == 2'b01, "R7 lowest remote", rem_gnt, 1);
    @(negedge clk);
    chk(rd_src == 1 && rd_data == 32'hA002, "R7 remote0 data", rd_data, 32'hA002);
    rem_req = 2'b10;
    #1 chk(rem_gnt == 2'b10, "R7 stalled remote served", rem_gnt, 2);
    @(negedge clk);
    chk(rd_src == 2 && rd_data == 32'hA004, "R7 remote1 data", rd_data, 32'hA004);
    rem_req = 0;

    // drowsy
    access(1, 1664, 32'h1111);
    @(negedge clk); sched_we = 1; sched_drowsy = 16'h1000;
    @(negedge clk); sched_we = 0;
    chk(periph_on == 16'hEFFF && clamp_on == 16'h1000, "R8 schedule bits", clamp_on, 16'h1000);
    access(1, 1664, 32'h2222);
    chk(err == 1 && bank_en == 0, "R9 drowsy refused", bank_en, 0);
    access(0, 1665, '0);
    chk(err == 1 && rd_valid == 0, "R9 drowsy read refused", err, 1);
    @(negedge clk); sched_we = 1; sched_drowsy = 16'h0000;
    @(negedge clk); sched_we = 0; loc_req = 1; loc_we = 0; loc_addr = 13'd1664;
    @(negedge clk);
    chk(err == 1 && bank_en == 0, "R10 waking refused", err, 1);
    chk(periph_on == 16'hFFFF, "R8 wake bits", periph_on, 16'hFFFF);
    @(negedge clk);
    loc_req = 0;
    chk(err == 0 && bank_en == 16'h1000, "R10 awake", bank_en, 16'h1000);
    chk(rd_data == 32'h1111, "R9 no write while drowsy", rd_data, 32'h1111);

    // sequential
    seq_mode = 1;
    access(0, 32, '0);
    chk(seq_hit == 0, "R11 first full decode", seq_hit, 0);
    access(0, 33, '0);
    chk(seq_hit == 1 && bank_en == 16'h0002 && field(0) == 1, "R11 reuse", seq_hit, 1);
    access(0, 62, '0);
    chk(seq_hit == 0, "R11 jump", seq_hit, 0);
    access(0, 63, '0);
    chk(seq_hit == 1 && field(0) == 31, "R11 last word", field(0), 31);
    access(0, 64, '0);
    chk(seq_hit == 0 && bank_en == 16'h0004 && field(0) == 0, "R11 boundary", bank_en, 16'h0004);
    seq_mode = 0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule